// File: doc/BRIEF.md
# Expansion ROM Window Decoder with Subsystem Identification

This block sits inside a PCI target's configuration space. It provides three registers. Two are 16-bit subsystem identification values that the host can read but never write. The third is a 32-bit expansion ROM base address register. The host places the ROM on a 1 MB boundary through its top 12 bits, and it turns decoding on with bit 0. Configuration accesses arrive as a dword index with four byte enables. Reads are combinational from the index.

On every address phase the block compares the bus address with the programmed window. One clock later it raises a device-select request when the ROM window is hit. A hit needs a memory read command, the ROM enable bit set, and the command register's memory-enable bit set. The two identification values are loaded through a side port, normally fed from nonvolatile storage at startup.

A hard reset clears everything. A soft reset leaves all three registers intact and only drops a claim that is still pending.

Top module: `xrom_cfg_decode`

## Requirements
- R1: After hard reset (rst_ni low), every register reads zero and devsel_req_o is 0.
- R2: The side port (ssid_ld_i high) loads ssid_ld_data_i into the vendor value when ssid_ld_sel_i is 0, and into the subsystem value when it is 1. Dword index 0x0B (byte offset 2Ch) reads {subsystem[15:0], vendor[15:0]}.
- R3: Configuration writes to dword index 0x0B do not change either identification value.
- R4: Dword index 0x0C (byte offset 30h) reads {base[11:0], 19'b0, rom_en}. Writing FFFFFFFFh with all byte enables set reads back FFF00001h.
- R5: Byte enables gate writes to index 0x0C. Enable bit 3 covers base bits 11:4 (address bits 31:24). Enable bit 2 covers base bits 3:0 (address bits 23:20). Enable bit 0 covers rom_en.
- R6: Reads of any dword index other than 0x0B and 0x0C return zero.
- R7: A claim is made only when rom_en is 1, mem_en_i is 1, and bus_cmd_i is one of 4'h6, 4'hE or 4'hC. No other command code is ever claimed.
- R8: A claim needs bus_addr_i[31:20] to equal the base. Every address from base<<20 up to (base<<20)+FFFFCh hits, and addresses outside that range miss.
- R9: devsel_req_o rises at the first clock edge after addr_vld_i is sampled high with a hit. It stays high for one cycle per address phase.
- R10: A soft reset (soft_rst_i high) leaves the base, rom_en and both identification values unchanged. It cancels a claim for an address phase presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, active low, asynchronous |
| soft_rst_i | input | 1 | Soft reset, synchronous |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration dword index |
| cfg_be_i | input | 4 | Configuration write byte enables |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for cfg_addr_i |
| ssid_ld_i | input | 1 | Identification load strobe |
| ssid_ld_sel_i | input | 1 | Load target: 0 vendor, 1 subsystem |
| ssid_ld_data_i | input | 16 | Identification load value |
| mem_en_i | input | 1 | Memory-enable bit from the command register |
| addr_vld_i | input | 1 | Address phase strobe |
| bus_addr_i | input | 32 | Bus address during the address phase |
| bus_cmd_i | input | 4 | Bus command during the address phase |
| devsel_req_o | output | 1 | Registered device-select request |

## Verification
A corrupted base or enable register shows up at the next configuration read of index 0x0C. It also appears one clock after the next address phase as a wrong devsel_req_o, either claiming outside the window or missing inside it. A bad identification value is visible on the very next read of index 0x0B. A claim register that fails to clear shows as a request lasting two cycles, or as a request that survives a soft reset. For these reasons the bench probes both window edges and every gating input, one at a time.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_MEM_RD      = 4'h6;
  localparam logic [CMD_W-1:0] CMD_MEM_RD_LINE = 4'hE;
  localparam logic [CMD_W-1:0] CMD_MEM_RD_MULT = 4'hC;

  function automatic logic is_rom_cmd(input logic [CMD_W-1:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_LINE) || (cmd == CMD_MEM_RD_MULT);
  endfunction
endpackage

// File: rtl/xrom_subsys_regs.sv
module xrom_subsys_regs #(
  parameter int ID_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic            ld_sel_i,
  input  logic [ID_W-1:0] ld_data_i,
  output logic [ID_W-1:0] vend_o,
  output logic [ID_W-1:0] subsys_o
);
  logic [ID_W-1:0] vend_q, subsys_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vend_q   <= '0;
      subsys_q <= '0;
    end else if (ld_i) begin
      if (ld_sel_i) subsys_q <= ld_data_i;
      else          vend_q   <= ld_data_i;
    end
  end

  assign vend_o   = vend_q;
  assign subsys_o = subsys_q;

  assert_ld_target_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && !ld_sel_i |=> vend_q == $past(ld_data_i) && $stable(subsys_q));
endmodule

// File: rtl/xrom_base_reg.sv
module xrom_base_reg #(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W/8-1:0] be_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [BASE_W-1:0] base_o,
  output logic              en_o
);
  localparam int NBYTE = ADDR_W / 8;

  logic [ADDR_W-1:0] bmask;
  logic [BASE_W-1:0] base_q, base_m;
  logic              en_q;

  for (genvar b = 0; b < NBYTE; b++) begin : g_bmask
    assign bmask[b*8 +: 8] = {8{be_i[b]}};
  end

  assign base_m = bmask[ADDR_W-1 -: BASE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_i) begin
      base_q <= (base_q & ~base_m) | (wdata_i[ADDR_W-1 -: BASE_W] & base_m);
      if (be_i[0]) en_q <= wdata_i[0];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[ADDR_W-BASE_W-1:1], bmask[ADDR_W-BASE_W-1:0]};

  assign base_o = base_q;
  assign en_o   = en_q;

  // only a decoded config write may change the BAR (soft reset never does)
  assert_bar_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(base_q) && $stable(en_q));
  assert_en_be_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !be_i[0] |=> $stable(en_q));
endmodule

// File: rtl/xrom_window_cmp.sv
module xrom_window_cmp
  import xrom_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CMD_W-1:0]  bus_cmd_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              rom_en_i,
  input  logic              mem_en_i,
  output logic              claim_o
);
  logic hit, claim_q;

  assign hit = (bus_addr_i[ADDR_W-1 -: BASE_W] == base_i) && is_rom_cmd(bus_cmd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         claim_q <= 1'b0;
    else if (soft_rst_i) claim_q <= 1'b0;
    else                 claim_q <= addr_vld_i && rom_en_i && mem_en_i && hit;
  end

  logic unused_low;
  assign unused_low = ^bus_addr_i[ADDR_W-BASE_W-1:0];

  assign claim_o = claim_q;

  assert_claim_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_q |-> $past(rom_en_i) && $past(mem_en_i) && $past(is_rom_cmd(bus_cmd_i)));
  assert_claim_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_q |-> $past(bus_addr_i[ADDR_W-1 -: BASE_W]) == $past(base_i));
  assert_claim_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_q |-> $past(addr_vld_i));
  assert_soft_cancel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !claim_q);
endmodule

// File: rtl/xrom_cfg_decode.sv
module xrom_cfg_decode
  import xrom_pkg::*;
#(
  parameter int          CFG_AW    = 6,
  parameter int          ID_W      = 16,
  parameter int          BASE_W    = 12,
  parameter logic [5:0]  SSID_DW   = 6'h0B,
  parameter logic [5:0]  ROMBAR_DW = 6'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              ssid_ld_i,
  input  logic              ssid_ld_sel_i,
  input  logic [ID_W-1:0]   ssid_ld_data_i,
  input  logic              mem_en_i,
  input  logic              addr_vld_i,
  input  logic [31:0]       bus_addr_i,
  input  logic [CMD_W-1:0]  bus_cmd_i,
  output logic              devsel_req_o
);
  localparam int ADDR_W = 32;
  localparam int GAP_W  = ADDR_W - BASE_W - 1;

  logic [ID_W-1:0]   vend, subsys;
  logic [BASE_W-1:0] base;
  logic              rom_en, bar_wr;

  assign bar_wr = cfg_wr_i && (cfg_addr_i == ROMBAR_DW[CFG_AW-1:0]);

  xrom_subsys_regs #(.ID_W(ID_W)) u_ssid (
    .clk_i, .rst_ni,
    .ld_i(ssid_ld_i), .ld_sel_i(ssid_ld_sel_i), .ld_data_i(ssid_ld_data_i),
    .vend_o(vend), .subsys_o(subsys)
  );

  xrom_base_reg #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_bar (
    .clk_i, .rst_ni,
    .wr_i(bar_wr), .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
    .base_o(base), .en_o(rom_en)
  );

  xrom_window_cmp #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_cmp (
    .clk_i, .rst_ni, .soft_rst_i,
    .addr_vld_i, .bus_addr_i, .bus_cmd_i,
    .base_i(base), .rom_en_i(rom_en), .mem_en_i(mem_en_i),
    .claim_o(devsel_req_o)
  );

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_addr_i == SSID_DW[CFG_AW-1:0])
      cfg_rdata_o = {{(16-ID_W){1'b0}}, subsys, {(16-ID_W){1'b0}}, vend};
    else if (cfg_addr_i == ROMBAR_DW[CFG_AW-1:0])
      cfg_rdata_o = {base, {GAP_W{1'b0}}, rom_en};
  end

  assert_ssid_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ssid_ld_i |=> $stable(vend) && $stable(subsys));
  assert_bar_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == ROMBAR_DW[CFG_AW-1:0]) |-> cfg_rdata_o[ADDR_W-BASE_W-1:1] == '0);
endmodule

// File: tb/xrom_cfg_decode_tb.sv
module xrom_cfg_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        ssid_ld_i = 1'b0;
  logic        ssid_ld_sel_i = 1'b0;
  logic [15:0] ssid_ld_data_i = '0;
  logic        mem_en_i = 1'b0;
  logic        addr_vld_i = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic [3:0]  bus_cmd_i = '0;
  logic        devsel_req_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  xrom_cfg_decode dut_i (
    .clk_i(clk), .rst_ni, .soft_rst_i, .cfg_wr_i, .cfg_addr_i, .cfg_be_i,
    .cfg_wdata_i, .cfg_rdata_o, .ssid_ld_i, .ssid_ld_sel_i, .ssid_ld_data_i,
    .mem_en_i, .addr_vld_i, .bus_addr_i, .bus_cmd_i, .devsel_req_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
    @(negedge clk);
    cfg_wr_i = 1'b0; cfg_be_i = '0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
  endtask

  task automatic ssid_load(input logic sel, input logic [15:0] d);
    @(negedge clk);
    ssid_ld_i = 1'b1; ssid_ld_sel_i = sel; ssid_ld_data_i = d;
    @(negedge clk);
    ssid_ld_i = 1'b0;
  endtask

  // one address phase; returns devsel one clock later and one clock after that
  task automatic addr_phase(input logic [31:0] a, input logic [3:0] cmd,
                            output logic first, output logic second);
    @(negedge clk);
    addr_vld_i = 1'b1; bus_addr_i = a; bus_cmd_i = cmd;
    @(negedge clk);
    addr_vld_i = 1'b0;
    first = devsel_req_o;
    @(negedge clk);
    second = devsel_req_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    cfg_read(6'h0B, d); chk("R1 ssid reset", d, 32'h0);
    cfg_read(6'h0C, d); chk("R1 bar reset", d, 32'h0);
    chk("R1 devsel reset", {31'b0, devsel_req_o}, 32'h0);
  endtask

  task automatic t_ssid();
    logic [31:0] d;
    ssid_load(1'b0, 16'h1022);
    ssid_load(1'b1, 16'hBEEF);
    cfg_read(6'h0B, d); chk("R2 ssid load", d, 32'hBEEF_1022);
    cfg_write(6'h0B, 4'hF, 32'h0000_0000);
    cfg_read(6'h0B, d); chk("R3 ssid write ignored", d, 32'hBEEF_1022);
  endtask

  task automatic t_rom_bar();
    logic [31:0] d;
    cfg_write(6'h0C, 4'hF, 32'hFFFF_FFFF);
    cfg_read(6'h0C, d); chk("R4 bar size probe", d, 32'hFFF0_0001);
    cfg_write(6'h0C, 4'hF, 32'h0000_0000);
    cfg_read(6'h0C, d); chk("R4 bar clear", d, 32'h0);
  endtask

  task automatic t_byte_en();
    logic [31:0] d;
    cfg_write(6'h0C, 4'b1000, 32'hABCD_EF01);
    cfg_read(6'h0C, d); chk("R5 be3 only", d, 32'hAB00_0000);
    cfg_write(6'h0C, 4'b0100, 32'h0050_0001);
    cfg_read(6'h0C, d); chk("R5 be2 only", d, 32'hAB50_0000);
    cfg_write(6'h0C, 4'b0001, 32'hFFFF_FFFF);
    cfg_read(6'h0C, d); chk("R5 be0 only", d, 32'hAB50_0001);
    cfg_write(6'h0C, 4'b0000, 32'h0000_0000);
    cfg_read(6'h0C, d); chk("R5 no be", d, 32'hAB50_0001);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    cfg_read(6'h00, d); chk("R6 idx 00", d, 32'h0);
    cfg_read(6'h0D, d); chk("R6 idx 0D", d, 32'h0);
    cfg_read(6'h3F, d); chk("R6 idx 3F", d, 32'h0);
  endtask

  task automatic t_claim_gate();
    logic f, s;
    cfg_write(6'h0C, 4'hF, 32'h1230_0001);
    mem_en_i = 1'b1;
    addr_phase(32'h1234_5678, 4'h6, f, s); chk("R7 mem read claimed", {31'b0, f}, 32'h1);
    addr_phase(32'h1234_5678, 4'hE, f, s); chk("R7 read line claimed", {31'b0, f}, 32'h1);
    addr_phase(32'h1234_5678, 4'hC, f, s); chk("R7 read mult claimed", {31'b0, f}, 32'h1);
    addr_phase(32'h1234_5678, 4'h7, f, s); chk("R7 mem write not claimed", {31'b0, f}, 32'h0);
    addr_phase(32'h1234_5678, 4'h2, f, s); chk("R7 io read not claimed", {31'b0, f}, 32'h0);
    mem_en_i = 1'b0;
    addr_phase(32'h1234_5678, 4'h6, f, s); chk("R7 mem_en off", {31'b0, f}, 32'h0);
    mem_en_i = 1'b1;
    cfg_write(6'h0C, 4'b0001, 32'h0000_0000);
    addr_phase(32'h1234_5678, 4'h6, f, s); chk("R7 rom_en off", {31'b0, f}, 32'h0);
    cfg_write(6'h0C, 4'b0001, 32'h0000_0001);
  endtask

  task automatic t_window();
    logic f, s;
    addr_phase(32'h1230_0000, 4'h6, f, s); chk("R8 low edge hit", {31'b0, f}, 32'h1);
    addr_phase(32'h123F_FFFC, 4'h6, f, s); chk("R8 high edge hit", {31'b0, f}, 32'h1);
    addr_phase(32'h122F_FFFC, 4'h6, f, s); chk("R8 below miss", {31'b0, f}, 32'h0);
    addr_phase(32'h1240_0000, 4'h6, f, s); chk("R8 above miss", {31'b0, f}, 32'h0);
  endtask

  task automatic t_pulse();
    logic f, s;
    addr_phase(32'h1238_0000, 4'h6, f, s);
    chk("R9 pulse first cycle", {31'b0, f}, 32'h1);
    chk("R9 pulse drops", {31'b0, s}, 32'h0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    @(negedge clk);
    soft_rst_i = 1'b1;
    addr_vld_i = 1'b1; bus_addr_i = 32'h1230_0040; bus_cmd_i = 4'h6;
    @(negedge clk);
    soft_rst_i = 1'b0; addr_vld_i = 1'b0;
    chk("R10 claim cancelled", {31'b0, devsel_req_o}, 32'h0);
    cfg_read(6'h0C, d); chk("R10 bar kept", d, 32'h1230_0001);
    cfg_read(6'h0B, d); chk("R10 ssid kept", d, 32'hBEEF_1022);
  endtask

  task automatic t_hard_reset();
    logic [31:0] d;
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    cfg_read(6'h0C, d); chk("R1 bar cleared by hard reset", d, 32'h0);
    cfg_read(6'h0B, d); chk("R1 ssid cleared by hard reset", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_ssid();
    t_rom_bar();
    t_byte_en();
    t_unimpl();
    t_claim_gate();
    t_window();
    t_pulse();
    t_soft_reset();
    t_hard_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule